// File: doc/BRIEF.md
# Interrupt Routing and Masking Unit

This block decides, for a processor with four privilege levels (0 to 3), which privilege level a pending fast interrupt (FIQ) or normal interrupt (IRQ) should be delivered to, and whether that interrupt may be taken at the current level. It looks at the current level, the security state, the hypervisor override and trap-general controls, the monitor routing controls and the processor's local FIQ and IRQ mask bits. When an interrupt may be taken, it raises a registered take strobe for one cycle and reports the interrupt type and the target level.

Requests are level-sensitive. When a decision has been issued, the block makes no new decision until the core acknowledges it. If both types can be taken in the same cycle, FIQ wins. Vector generation, register banking, context saving and the change of security state are left to the core.

Top module: `irq_route_unit`

## Requirements
- R1: With no override, trap-general or monitor routing bit in effect, the target level of either interrupt type is 1.
- R2: In non-secure state (secureState=0), a set override bit for a type (hypFiqOvr for FIQ, hypIrqOvr for IRQ) makes the target level 2; in secure state the override bits do not change the target.
- R3: A set monitor routing bit for a type (monFiqRoute, monIrqRoute) makes the target level 3, ahead of any level 2 routing, in either security state.
- R4: An interrupt is never taken while the current level is above its target level.
- R5: In non-secure state, when the current level is below 2 and the target is level 2 because of an override, the interrupt is taken even if its local mask bit is set.
- R6: When the current level is 2 and the target is level 2, the local mask bit is honoured.
- R7: When hypTrapAll is 1, both override bits act as 1 for routing and for the mask bypass, whatever their own values.
- R8: In every other case an interrupt is taken only when its mask bit (fiqMask, irqMask) is 0.
- R9: When both types can be taken in the same cycle, FIQ is chosen (takeIsFiq=1 for FIQ, 0 for IRQ).
- R10: Inputs are sampled at a clock edge; if an interrupt can be taken, takeValid is 1 for exactly the following cycle, with takeIsFiq and takeLevel (2-bit binary) valid then and held until takeAck. No new decision is made until takeAck is seen; takeAck while no decision is outstanding has no effect. After reset takeValid, takeIsFiq and takeLevel are 0.
- R11: A current level of 0 is routed and compared exactly as level 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curLevel | input | 2 | Current privilege level |
| secureState | input | 1 | 1 = secure state |
| hypFiqOvr | input | 1 | Hypervisor FIQ override |
| hypIrqOvr | input | 1 | Hypervisor IRQ override |
| hypTrapAll | input | 1 | Hypervisor trap-general control |
| monFiqRoute | input | 1 | Monitor routing for FIQ |
| monIrqRoute | input | 1 | Monitor routing for IRQ |
| fiqMask | input | 1 | Local FIQ mask |
| irqMask | input | 1 | Local IRQ mask |
| fiqReq | input | 1 | FIQ request, level-sensitive |
| irqReq | input | 1 | IRQ request, level-sensitive |
| takeAck | input | 1 | Core has accepted the decision |
| takeValid | output | 1 | One-cycle take strobe |
| takeIsFiq | output | 1 | 1 = FIQ chosen, 0 = IRQ chosen |
| takeLevel | output | 2 | Target privilege level of the taken interrupt |

## Verification
The assertions assume the control inputs are stable across the edge at which a decision is captured and that takeAck comes only as a reply to a strobe or while idle. The stimulus changes inputs only on falling edges, drops requests when it acknowledges so that a held request cannot retrigger unseen, and holds every control bit steady while a decision is outstanding except in the directed test that deliberately changes them to show the held outputs do not follow.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int LVL_W = 2;
  localparam int NUM_TYPES = 2;

  typedef struct packed {
    logic capture;
    logic fire;
  } route_ctrl_t;
endpackage

// File: rtl/irq_route_lane.sv
module irq_route_lane #(
  parameter int LVL_W = 2
) (
  input  logic [LVL_W-1:0] effLvl,
  input  logic             nonSecure,
  input  logic             ovrEff,
  input  logic             monRoute,
  input  logic             maskBit,
  input  logic             reqIn,
  output logic [LVL_W-1:0] tgtLvl,
  output logic             canTake
);
  localparam logic [LVL_W-1:0] MON_LVL = LVL_W'((1 << LVL_W) - 1);
  localparam logic [LVL_W-1:0] HYP_LVL = LVL_W'((1 << LVL_W) - 2);
  localparam logic [LVL_W-1:0] DEF_LVL = LVL_W'(1);

  logic hypBypass;
  logic levelOk;

  always_comb begin
    if (monRoute)
      tgtLvl = MON_LVL;
    else if (nonSecure && ovrEff)
      tgtLvl = HYP_LVL;
    else
      tgtLvl = DEF_LVL;
  end

  assign hypBypass = nonSecure && ovrEff && (effLvl < HYP_LVL) && (tgtLvl == HYP_LVL);
  assign levelOk   = (effLvl <= tgtLvl);
  assign canTake   = reqIn && levelOk && (hypBypass || !maskBit);
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int LVL_W = 2,
  parameter int NUM_T = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] curLvl,
  input  logic             secureState,
  input  logic [NUM_T-1:0] hypOvr,
  input  logic             hypTrapAll,
  input  logic [NUM_T-1:0] monRoute,
  input  logic [NUM_T-1:0] maskBits,
  input  logic [NUM_T-1:0] reqs,
  input  route_ctrl_t      ctrl,
  output logic             anyTake,
  output logic             takeIsFiq,
  output logic [LVL_W-1:0] takeLevel
);
  localparam int IDX_W = (NUM_T > 1) ? $clog2(NUM_T) : 1;
  localparam logic [LVL_W-1:0] MON_LVL = LVL_W'((1 << LVL_W) - 1);
  localparam logic [LVL_W-1:0] HYP_LVL = LVL_W'((1 << LVL_W) - 2);

  logic [LVL_W-1:0] effLvl;
  logic [NUM_T-1:0] laneTake;
  logic [LVL_W-1:0] laneTgt [NUM_T];
  logic [IDX_W-1:0] selIdx;
  logic [LVL_W-1:0] selTgt;

  // level 0 is routed as level 1
  assign effLvl = (curLvl == '0) ? LVL_W'(1) : curLvl;

  generate
    for (genvar t = 0; t < NUM_T; t++) begin : g_lane
      irq_route_lane #(.LVL_W(LVL_W)) u_lane (
        .effLvl   (effLvl),
        .nonSecure(!secureState),
        .ovrEff   (hypOvr[t] || hypTrapAll),
        .monRoute (monRoute[t]),
        .maskBit  (maskBits[t]),
        .reqIn    (reqs[t]),
        .tgtLvl   (laneTgt[t]),
        .canTake  (laneTake[t])
      );
    end
  endgenerate

  // lowest index (FIQ) has priority
  always_comb begin
    selIdx = '0;
    selTgt = laneTgt[0];
    for (int t = NUM_T - 1; t >= 0; t--) begin
      if (laneTake[t]) begin
        selIdx = IDX_W'(t);
        selTgt = laneTgt[t];
      end
    end
  end

  assign anyTake = |laneTake;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeIsFiq <= 1'b0;
      takeLevel <= '0;
    end else if (ctrl.capture) begin
      takeIsFiq <= (selIdx == '0);
      takeLevel <= selTgt;
    end
  end

  AST_TARGET_NOT_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> takeLevel >= $past(effLvl)); // R4
  AST_FIQ_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && reqs[0] && laneTake[0]) |=> takeIsFiq); // R9
  AST_MON_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && laneTake[0] && monRoute[0]) |=> takeLevel == MON_LVL); // R3
  AST_SECURE_NOT_HYP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && secureState) |=> takeLevel != HYP_LVL); // R2
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyTake,
  input  logic        takeAck,
  output route_ctrl_t ctrl,
  output logic        takeValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRE, ST_WAIT} state_t;
  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (anyTake) stateNext = ST_FIRE;
      ST_FIRE: stateNext = takeAck ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (takeAck) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign ctrl.capture = (state == ST_IDLE) && anyTake;
  assign ctrl.fire    = (state == ST_FIRE);
  assign takeValid    = ctrl.fire;

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |=> !takeValid); // R10
  AST_WAIT_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !takeAck) |=> !takeValid); // R10
  AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !anyTake) |=> !takeValid); // R10
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] curLevel,
  input  logic       secureState,
  input  logic       hypFiqOvr,
  input  logic       hypIrqOvr,
  input  logic       hypTrapAll,
  input  logic       monFiqRoute,
  input  logic       monIrqRoute,
  input  logic       fiqMask,
  input  logic       irqMask,
  input  logic       fiqReq,
  input  logic       irqReq,
  input  logic       takeAck,
  output logic       takeValid,
  output logic       takeIsFiq,
  output logic [1:0] takeLevel
);
  route_ctrl_t ctrl;
  logic        anyTake;

  irq_route_dp #(.LVL_W(LVL_W), .NUM_T(NUM_TYPES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .curLvl     (curLevel),
    .secureState(secureState),
    .hypOvr     ({hypIrqOvr, hypFiqOvr}),
    .hypTrapAll (hypTrapAll),
    .monRoute   ({monIrqRoute, monFiqRoute}),
    .maskBits   ({irqMask, fiqMask}),
    .reqs       ({irqReq, fiqReq}),
    .ctrl       (ctrl),
    .anyTake    (anyTake),
    .takeIsFiq  (takeIsFiq),
    .takeLevel  (takeLevel)
  );

  irq_route_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .anyTake  (anyTake),
    .takeAck  (takeAck),
    .ctrl     (ctrl),
    .takeValid(takeValid)
  );
endmodule

// File: tb/sim_irq_route_unit.sv
`timescale 1ns/1ps
module sim_irq_route_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] curLevel = 2'd1;
  logic secureState = 0, hypFiqOvr = 0, hypIrqOvr = 0, hypTrapAll = 0;
  logic monFiqRoute = 0, monIrqRoute = 0, fiqMask = 0, irqMask = 0;
  logic fiqReq = 0, irqReq = 0, takeAck = 0;
  logic takeValid, takeIsFiq;
  logic [1:0] takeLevel;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_route_unit u0 (.*);

  // fields: cur(2) sec fmo imo tge | monF monI | mF mI | rF rI | expTake expFiq | expLvl(2) | req(4)
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    20'b01_0000_00_00_01_10_01_0001, // R1 IRQ default
    20'b01_0000_00_00_10_11_01_0001, // R1 FIQ default
    20'b01_0010_00_00_01_10_10_0010, // R2 non-secure override
    20'b01_1010_00_00_01_10_01_0010, // R2 secure ignores override
    20'b01_0100_10_00_10_11_11_0011, // R3 monitor over override
    20'b11_1000_01_00_01_10_11_0011, // R3 secure monitor at level 3
    20'b10_0000_00_00_01_00_00_0100, // R4 level 2 above target 1
    20'b11_0100_00_00_10_00_00_0100, // R4 level 3 above target 2
    20'b01_0100_00_10_10_11_10_0101, // R5 FIQ mask bypassed
    20'b00_0010_00_01_01_10_10_0101, // R5 IRQ mask bypassed from level 0
    20'b10_0010_00_01_01_00_00_0110, // R6 level 2 mask honoured
    20'b10_0010_00_00_01_10_10_0110, // R6 level 2 unmasked
    20'b01_0001_00_10_10_11_10_0111, // R7 trap-general FIQ
    20'b01_0001_00_01_01_10_10_0111, // R7 trap-general IRQ
    20'b01_0000_00_10_10_00_00_1000, // R8 FIQ masked
    20'b01_1100_00_10_10_00_00_1000, // R8 secure override, masked
    20'b01_0000_00_00_11_11_01_1001, // R9 both, FIQ wins
    20'b01_0000_00_10_11_10_01_1001, // R9 FIQ masked, IRQ taken
    20'b00_0000_00_00_10_11_01_1011, // R11 level 0 like level 1
    20'b01_1000_10_10_10_00_00_1000  // R8 monitor target, mask kept
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearIn();
    {secureState, hypFiqOvr, hypIrqOvr, hypTrapAll} = '0;
    {monFiqRoute, monIrqRoute, fiqMask, irqMask, fiqReq, irqReq} = '0;
    curLevel = 2'd1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(takeValid == 0, "R10 reset valid", takeValid, 0);
    check(takeLevel == 0, "R10 reset level", takeLevel, 0);
    check(takeIsFiq == 0, "R10 reset type", takeIsFiq, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d", v[3:0]);
      curLevel = v[19:18];
      {secureState, hypFiqOvr, hypIrqOvr, hypTrapAll} = v[17:14];
      {monFiqRoute, monIrqRoute} = v[13:12];
      {fiqMask, irqMask} = v[11:10];
      {fiqReq, irqReq} = v[9:8];
      @(negedge clk);
      check(takeValid == v[7], tag, takeValid, v[7]);
      if (v[7]) begin
        check(takeIsFiq == v[6], tag, takeIsFiq, v[6]);
        check(takeLevel == v[5:4], tag, takeLevel, v[5:4]);
        fiqReq = 0; irqReq = 0; takeAck = 1;
        @(negedge clk);
        takeAck = 0;
      end else begin
        fiqReq = 0; irqReq = 0;
        @(negedge clk);
      end
      check(takeValid == 0, tag, takeValid, 0);
      clearIn();
      @(negedge clk);
    end

    // R10 hold without acknowledge, request kept high, inputs changed
    fiqReq = 1;
    @(negedge clk);
    check(takeValid == 1, "R10 strobe", takeValid, 1);
    fiqReq = 0; irqReq = 1; hypIrqOvr = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(takeValid == 0, "R10 no new decision", takeValid, 0);
      check(takeIsFiq == 1, "R10 type held", takeIsFiq, 1);
      check(takeLevel == 1, "R10 level held", takeLevel, 1);
    end
    takeAck = 1;
    @(negedge clk);
    takeAck = 0;
    check(takeValid == 0, "R10 ack cycle", takeValid, 0);
    @(negedge clk);
    check(takeValid == 1, "R10 retrigger", takeValid, 1);
    check(takeIsFiq == 0 && takeLevel == 2, "R10 new decision", {takeIsFiq, takeLevel}, 2);
    irqReq = 0; takeAck = 1;
    @(negedge clk);
    takeAck = 0;
    clearIn();

    // R10 acknowledge while idle has no effect
    takeAck = 1;
    @(negedge clk);
    takeAck = 0;
    check(takeValid == 0, "R10 idle ack", takeValid, 0);
    irqReq = 1;
    @(negedge clk);
    check(takeValid == 1 && takeLevel == 1, "R10 after idle ack", {takeValid, takeLevel}, 5);
    irqReq = 0; takeAck = 1;
    @(negedge clk);
    takeAck = 0;
    @(negedge clk);

    // R7 trap-general with secure state: no level 2 routing
    secureState = 1; hypTrapAll = 1; irqReq = 1;
    @(negedge clk);
    check(takeValid == 1 && takeLevel == 1, "R7 secure trap-general", {takeValid, takeLevel}, 5);
    irqReq = 0; takeAck = 1;
    @(negedge clk);
    takeAck = 0;
    clearIn();
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule